// File: doc/BRIEF.md
# Envelope Min/Max Waveform Accumulator

This block merges a stream of newly captured 8-bit unsigned samples into an internal waveform save memory that is split into six pages. Pages 0 and 1 hold the two channel sources. Pages 2 to 5 hold the four reference destinations. Each sample arrives with its record position (0 to 511) and is qualified by a mode select and a page select that are sampled along with it.

In direct mode a sample is copied unchanged into its page at the word matching its position. In envelope mode each record position owns two words: the even word keeps the running maximum and the odd word keeps the running minimum across acquisitions. The stored pair is first read into holding registers and compared with the sample. A word is rewritten only when the sample beats it. After reset, or after a clear of that page, the first pass seeds both words unconditionally. A separate host read port returns any word of any page while no merge is in flight.

Top module: `envelope_accum`

## Requirements
- R1: After reset, s_ready_o is 1, err_o is 0, rd_valid_o is 0, and every page is in the seeding state.
- R2: In direct mode (mode_i = 0), a sample with position p on a valid page k is written unchanged to word p of page k in the accepting cycle, and s_ready_o stays 1 so that one sample can be taken every cycle.
- R3: In envelope mode (mode_i = 1) with a valid page, s_ready_o is 0 for exactly the two cycles after acceptance (read, compare, write), so samples are taken at most one per three cycles.
- R4: While a page is seeding, an envelope sample at position p writes its value to both word 2p (max) and word 2p+1 (min).
- R5: Once a page has finished seeding, word 2p is replaced only if the sample is strictly greater than it, and word 2p+1 is replaced only if the sample is strictly smaller than it. Equal values leave both words unchanged.
- R6: Seeding of a page ends when an envelope sample at position 511 on that page has been merged. Other pages keep their own seeding state.
- R7: A clear_i pulse with a valid page_i puts that page back into seeding and leaves the other pages alone. Any clear_i pulse also drops err_o.
- R8: A sample offered with page_i of 6 or 7 is accepted without a stall and writes nothing. It sets err_o, which stays 1 until a clear_i pulse.
- R9: rd_ready_o is 1 only while the sequencer is idle and s_valid_i is 0. An accepted read gives rd_valid_o = 1 in the next cycle, with the word in rd_data_o, or 0 if rd_page_i was 6 or 7.
- R10: The six pages are independent. A write to one page never changes a word of another page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| s_valid_i | input | 1 | Sample offered |
| s_ready_o | output | 1 | Sample can be taken this cycle |
| s_data_i | input | 8 | Unsigned sample value |
| s_pos_i | input | 9 | Record position of the sample |
| mode_i | input | 1 | 0 direct copy, 1 envelope merge |
| page_i | input | 3 | Page of the sample and of clear_i: 0,1 channels, 2..5 references |
| clear_i | input | 1 | Restart envelope seeding of page_i and drop err_o |
| err_o | output | 1 | Sticky flag for a sample sent to a page that does not exist |
| rd_req_i | input | 1 | Host read request |
| rd_ready_o | output | 1 | Host read can be taken this cycle |
| rd_page_i | input | 3 | Host read page |
| rd_addr_i | input | 10 | Host read word address within the page |
| rd_valid_o | output | 1 | Host read data valid |
| rd_data_o | output | 8 | Host read data |

## Verification
The bench runs the page past its own seeding pass and sends samples equal to the stored max and min, plus samples at 0x00 and 0xFF. A comparison that is not strict, or that uses the wrong sign, would then rewrite a word that must stay put. It checks that a second pass on a page that has not reached position 511 still seeds both words, so a global seeding flag or one that ends early shows up as a stale min. Samples sent to pages 6 and 7 must neither stall nor land in page 0, which catches a wrapped index. Host reads tried while a sample is offered or a merge is in flight must be refused, or the shared read port would return data from the merge.

// File: rtl/envelope_accum_pkg.sv
package envelope_accum_pkg;

  typedef enum logic {
    MODE_DIRECT   = 1'b0,
    MODE_ENVELOPE = 1'b1
  } acq_mode_e;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_HOLD  = 2'd1,
    SEQ_MERGE = 2'd2
  } seq_state_e;

  localparam int unsigned NUM_BANKS = 2;
  localparam int unsigned BANK_MAX  = 0;
  localparam int unsigned BANK_MIN  = 1;

  function automatic int unsigned flat_idx(input int unsigned pg, input int unsigned off,
                                           input int unsigned rec_len);
    return pg * rec_len + off;
  endfunction

endpackage

// File: rtl/env_ram_bank.sv
module env_ram_bank #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 3072,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    if (re_i) rdata_o <= mem_q[raddr_i];
  end

  AST_WADDR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> (32'(waddr_i) < DEPTH)); // R8

endmodule

// File: rtl/env_seq.sv
module env_seq
  import envelope_accum_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned REC_LEN   = 512,
  parameter int unsigned NUM_PAGES = 6,
  localparam int unsigned POS_W    = $clog2(REC_LEN),
  localparam int unsigned PAGE_W   = $clog2(NUM_PAGES),
  localparam int unsigned IDX_W    = $clog2(NUM_PAGES * REC_LEN)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 s_valid_i,
  output logic                 s_ready_o,
  input  logic [DATA_W-1:0]    s_data_i,
  input  logic [POS_W-1:0]     s_pos_i,
  input  logic                 mode_i,
  input  logic [PAGE_W-1:0]    page_i,
  input  logic                 clear_i,
  output logic                 err_o,
  output logic                 busy_o,
  output logic                 rd_en_o,
  output logic [IDX_W-1:0]     rd_idx_o,
  input  logic [DATA_W-1:0]    q_max_i,
  input  logic [DATA_W-1:0]    q_min_i,
  output logic [NUM_BANKS-1:0] wr_en_o,
  output logic [IDX_W-1:0]     wr_idx_o,
  output logic [DATA_W-1:0]    wr_data_o
);

  localparam logic [POS_W-1:0] LAST_POS = POS_W'(REC_LEN - 1);

  seq_state_e        state_q, state_d;
  logic [DATA_W-1:0] smp_q, hold_max_q, hold_min_q;
  logic [POS_W-1:0]  pos_q;
  logic [PAGE_W-1:0] pg_q;
  logic [NUM_PAGES-1:0] seed_q;
  logic              err_q;

  logic page_ok, accept, env_go, dir_go, bad_go;
  logic in_merge, seed_cur, upd_max, upd_min, merge_last;

  assign page_ok = 32'(page_i) < NUM_PAGES;
  assign accept  = s_valid_i && (state_q == SEQ_IDLE);
  assign env_go  = accept && page_ok && (acq_mode_e'(mode_i) == MODE_ENVELOPE);
  assign dir_go  = accept && page_ok && (acq_mode_e'(mode_i) == MODE_DIRECT);
  assign bad_go  = accept && !page_ok;

  assign s_ready_o = (state_q == SEQ_IDLE);
  assign busy_o    = (state_q != SEQ_IDLE);
  assign err_o     = err_q;
  assign in_merge  = (state_q == SEQ_MERGE);

  // previous acquisition's pair is fetched in the accepting cycle
  assign rd_en_o  = env_go;
  assign rd_idx_o = IDX_W'(flat_idx(int'(page_i), int'(s_pos_i), REC_LEN));

  always_comb begin
    seed_cur = 1'b0;
    for (int p = 0; p < NUM_PAGES; p++) begin
      if (int'(pg_q) == p) seed_cur = seed_q[p];
    end
  end

  assign upd_max    = seed_cur || (smp_q > hold_max_q);
  assign upd_min    = seed_cur || (smp_q < hold_min_q);
  assign merge_last = in_merge && (pos_q == LAST_POS);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE:  if (env_go) state_d = SEQ_HOLD;
      SEQ_HOLD:  state_d = SEQ_MERGE;
      SEQ_MERGE: state_d = SEQ_IDLE;
      default:   state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEQ_IDLE;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q <= '0;
      pos_q <= '0;
      pg_q  <= '0;
    end else if (env_go) begin
      smp_q <= s_data_i;
      pos_q <= s_pos_i;
      pg_q  <= page_i;
    end
  end

  // second holding stage: stored max/min of the previous acquisition
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_max_q <= '0;
      hold_min_q <= '0;
    end else if (state_q == SEQ_HOLD) begin
      hold_max_q <= q_max_i;
      hold_min_q <= q_min_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seed_q <= '1;
    end else begin
      for (int p = 0; p < NUM_PAGES; p++) begin
        if (clear_i && (int'(page_i) == p))          seed_q[p] <= 1'b1;
        else if (merge_last && (int'(pg_q) == p))    seed_q[p] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      err_q <= 1'b0;
    else if (bad_go)  err_q <= 1'b1;
    else if (clear_i) err_q <= 1'b0;
  end

  always_comb begin
    wr_en_o   = '0;
    wr_idx_o  = IDX_W'(flat_idx(int'(page_i), int'(s_pos_i >> 1), REC_LEN));
    wr_data_o = s_data_i;
    if (in_merge) begin
      wr_en_o[BANK_MAX] = upd_max;
      wr_en_o[BANK_MIN] = upd_min;
      wr_idx_o  = IDX_W'(flat_idx(int'(pg_q), int'(pos_q), REC_LEN));
      wr_data_o = smp_q;
    end else if (dir_go) begin
      wr_en_o[s_pos_i[0]] = 1'b1;
    end
  end

  AST_ENV_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    env_go |=> !s_ready_o); // R3
  AST_HOLD_TO_MERGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_HOLD) |=> (state_q == SEQ_MERGE)); // R3
  AST_MERGE_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_merge |=> s_ready_o); // R3
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !clear_i) |=> err_o); // R8
  AST_SEED_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (merge_last && !clear_i) |=> !seed_cur); // R6
  AST_DIRECT_ONE_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_go |-> $onehot0(wr_en_o)); // R2

endmodule

// File: rtl/env_host_port.sv
module env_host_port
  import envelope_accum_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned REC_LEN   = 512,
  parameter int unsigned NUM_PAGES = 6,
  localparam int unsigned POS_W    = $clog2(REC_LEN),
  localparam int unsigned WA_W     = POS_W + 1,
  localparam int unsigned PAGE_W   = $clog2(NUM_PAGES),
  localparam int unsigned IDX_W    = $clog2(NUM_PAGES * REC_LEN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_req_i,
  input  logic [PAGE_W-1:0] rd_page_i,
  input  logic [WA_W-1:0]   rd_addr_i,
  output logic              rd_ready_o,
  input  logic              busy_i,
  input  logic              s_valid_i,
  output logic              re_o,
  output logic [IDX_W-1:0]  idx_o,
  input  logic [DATA_W-1:0] q_max_i,
  input  logic [DATA_W-1:0] q_min_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o
);

  logic take, page_ok;
  logic valid_q, ok_q, sel_q;

  assign rd_ready_o = !busy_i && !s_valid_i;
  assign take       = rd_req_i && rd_ready_o;
  assign page_ok    = 32'(rd_page_i) < NUM_PAGES;
  assign re_o       = take && page_ok;
  assign idx_o      = IDX_W'(flat_idx(int'(rd_page_i), int'(rd_addr_i[WA_W-1:1]), REC_LEN));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      ok_q    <= 1'b0;
      sel_q   <= 1'b0;
    end else begin
      valid_q <= take;
      if (take) begin
        ok_q  <= page_ok;
        sel_q <= rd_addr_i[0];
      end
    end
  end

  assign rd_valid_o = valid_q;
  assign rd_data_o  = !ok_q ? '0 : (sel_q ? q_min_i : q_max_i);

  AST_RD_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> rd_valid_o); // R9

endmodule

// File: rtl/envelope_accum.sv
module envelope_accum
  import envelope_accum_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned REC_LEN   = 512,
  parameter int unsigned NUM_PAGES = 6,
  localparam int unsigned POS_W    = $clog2(REC_LEN),
  localparam int unsigned WA_W     = POS_W + 1,
  localparam int unsigned PAGE_W   = $clog2(NUM_PAGES),
  localparam int unsigned IDX_W    = $clog2(NUM_PAGES * REC_LEN),
  localparam int unsigned BANK_DEPTH = NUM_PAGES * REC_LEN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              s_valid_i,
  output logic              s_ready_o,
  input  logic [DATA_W-1:0] s_data_i,
  input  logic [POS_W-1:0]  s_pos_i,
  input  logic              mode_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic              clear_i,
  output logic              err_o,
  input  logic              rd_req_i,
  output logic              rd_ready_o,
  input  logic [PAGE_W-1:0] rd_page_i,
  input  logic [WA_W-1:0]   rd_addr_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o
);

  logic                 busy, seq_re, host_re, bank_re;
  logic [IDX_W-1:0]     seq_ridx, host_ridx, bank_ridx, wr_idx;
  logic [NUM_BANKS-1:0] wr_en;
  logic [DATA_W-1:0]    wr_data;
  logic [DATA_W-1:0]    bank_q [NUM_BANKS];

  env_seq #(
    .DATA_W(DATA_W), .REC_LEN(REC_LEN), .NUM_PAGES(NUM_PAGES)
  ) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .s_valid_i(s_valid_i),
    .s_ready_o(s_ready_o),
    .s_data_i (s_data_i),
    .s_pos_i  (s_pos_i),
    .mode_i   (mode_i),
    .page_i   (page_i),
    .clear_i  (clear_i),
    .err_o    (err_o),
    .busy_o   (busy),
    .rd_en_o  (seq_re),
    .rd_idx_o (seq_ridx),
    .q_max_i  (bank_q[BANK_MAX]),
    .q_min_i  (bank_q[BANK_MIN]),
    .wr_en_o  (wr_en),
    .wr_idx_o (wr_idx),
    .wr_data_o(wr_data)
  );

  env_host_port #(
    .DATA_W(DATA_W), .REC_LEN(REC_LEN), .NUM_PAGES(NUM_PAGES)
  ) u_host (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_req_i  (rd_req_i),
    .rd_page_i (rd_page_i),
    .rd_addr_i (rd_addr_i),
    .rd_ready_o(rd_ready_o),
    .busy_i    (busy),
    .s_valid_i (s_valid_i),
    .re_o      (host_re),
    .idx_o     (host_ridx),
    .q_max_i   (bank_q[BANK_MAX]),
    .q_min_i   (bank_q[BANK_MIN]),
    .rd_valid_o(rd_valid_o),
    .rd_data_o (rd_data_o)
  );

  assign bank_re   = seq_re || host_re;
  assign bank_ridx = seq_re ? seq_ridx : host_ridx;

  // even words (max) in bank 0, odd words (min) in bank 1
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    env_ram_bank #(
      .DATA_W(DATA_W), .DEPTH(BANK_DEPTH)
    ) u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (wr_en[b]),
      .waddr_i(wr_idx),
      .wdata_i(wr_data),
      .re_i   (bank_re),
      .raddr_i(bank_ridx),
      .rdata_o(bank_q[b])
    );
  end

  AST_HOST_NO_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_re |-> (wr_en == '0)); // R9
  AST_READ_PORT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(seq_re && host_re)); // R9

endmodule

// File: tb/envelope_accum_tb_top.sv
module envelope_accum_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       s_valid = 1'b0;
  logic [7:0] s_data = '0;
  logic [8:0] s_pos = '0;
  logic       mode = 1'b0;
  logic [2:0] page = '0;
  logic       clear = 1'b0;
  logic       rd_req = 1'b0;
  logic [2:0] rd_page = '0;
  logic [9:0] rd_addr = '0;
  logic       s_ready, err, rd_ready, rd_valid;
  logic [7:0] rd_data;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  envelope_accum dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .s_valid_i(s_valid), .s_ready_o(s_ready), .s_data_i(s_data), .s_pos_i(s_pos),
    .mode_i(mode), .page_i(page), .clear_i(clear), .err_o(err),
    .rd_req_i(rd_req), .rd_ready_o(rd_ready), .rd_page_i(rd_page), .rd_addr_i(rd_addr),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, got, exp, $time);
    end
  endtask

  // behavioural reference model
  int  mem_m [6][1024];
  bit  seed_m [6];
  int  busy_m;
  bit  err_m;
  bit  rdv_m;
  int  rdd_m;

  always @(posedge clk) begin
    bit acc, rtake;
    int pg, ps, d;
    if (!rst_n) begin
      busy_m = 0; err_m = 0; rdv_m = 0; rdd_m = 0;
      for (int i = 0; i < 6; i++) seed_m[i] = 1;
    end else begin
      acc   = s_valid && (busy_m == 0);
      rtake = rd_req && (busy_m == 0) && !s_valid;
      rdv_m = rtake;
      if (rtake) rdd_m = (rd_page < 6) ? mem_m[rd_page][rd_addr] : 0;
      if (busy_m > 0) busy_m--;
      if (clear) begin
        err_m = 0;
        if (page < 6) seed_m[page] = 1;
      end
      if (acc) begin
        pg = int'(page); ps = int'(s_pos); d = int'(s_data);
        if (pg >= 6) err_m = 1;
        else if (!mode) mem_m[pg][ps] = d;
        else begin
          busy_m = 2;
          if (seed_m[pg]) begin
            mem_m[pg][2*ps] = d; mem_m[pg][2*ps+1] = d;
          end else begin
            if (d > mem_m[pg][2*ps])   mem_m[pg][2*ps] = d;
            if (d < mem_m[pg][2*ps+1]) mem_m[pg][2*ps+1] = d;
          end
          if (ps == 511) seed_m[pg] = 0;
        end
      end
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3 ready", int'(s_ready), int'(busy_m == 0));
      chk("R8 err", int'(err), int'(err_m));
      chk("R9 rd_ready", int'(rd_ready), int'((busy_m == 0) && !s_valid));
      chk("R9 rd_valid", int'(rd_valid), int'(rdv_m));
      if (rdv_m) chk("R9 rd_data", int'(rd_data), rdd_m);
    end
  end

  task automatic send(input bit m, input int pg, input int ps, input int d);
    mode = m; page = 3'(pg); s_pos = 9'(ps); s_data = 8'(d); s_valid = 1'b1;
    @(negedge clk);
    while (!s_ready) @(negedge clk);
    @(posedge clk); #1;
    s_valid = 1'b0;
  endtask

  task automatic host_read(input int pg, input int a, output int d);
    rd_page = 3'(pg); rd_addr = 10'(a); rd_req = 1'b1;
    @(negedge clk);
    while (!rd_ready) @(negedge clk);
    @(posedge clk); #1;
    rd_req = 1'b0;
    @(negedge clk);
    d = int'(rd_data);
  endtask

  task automatic do_clear(input int pg);
    page = 3'(pg); clear = 1'b1;
    @(posedge clk); #1;
    clear = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  initial begin
    int v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 ready in reset", int'(s_ready), 1);
    chk("R1 err in reset", int'(err), 0);
    chk("R1 rd_valid in reset", int'(rd_valid), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    idle(2);

    // R2 direct, back to back on page 0
    for (int i = 0; i < 8; i++) send(1'b0, 0, i, i * 17 + 1);
    for (int i = 0; i < 8; i++) begin
      host_read(0, i, v);
      chk("R2 direct word", v, i * 17 + 1);
    end

    // R10 page independence
    send(1'b0, 1, 3, 8'hA5);
    idle(1);
    host_read(1, 3, v); chk("R10 page1 word", v, 8'hA5);
    host_read(0, 3, v); chk("R10 page0 untouched", v, 3 * 17 + 1);

    // R4 seeding and R3 stall length
    send(1'b1, 2, 5, 8'h40);
    @(negedge clk); chk("R3 stall cycle 1", int'(s_ready), 0);
    @(negedge clk); chk("R3 stall cycle 2", int'(s_ready), 0);
    @(negedge clk); chk("R3 ready again", int'(s_ready), 1);
    idle(1);
    host_read(2, 10, v); chk("R4 seed max", v, 8'h40);
    host_read(2, 11, v); chk("R4 seed min", v, 8'h40);

    // R6 end of seeding at last position
    send(1'b1, 2, 511, 8'h80);
    send(1'b1, 2, 5, 8'h50);
    send(1'b1, 2, 5, 8'h30);
    idle(3);
    host_read(2, 10, v); chk("R5 max raised", v, 8'h50);
    host_read(2, 11, v); chk("R5 min lowered", v, 8'h30);
    send(1'b1, 2, 5, 8'h50);
    send(1'b1, 2, 5, 8'h30);
    send(1'b1, 2, 5, 8'h45);
    idle(3);
    host_read(2, 10, v); chk("R5 equal max kept", v, 8'h50);
    host_read(2, 11, v); chk("R5 equal min kept", v, 8'h30);
    send(1'b1, 2, 5, 8'hFF);
    send(1'b1, 2, 5, 8'h00);
    idle(3);
    host_read(2, 10, v); chk("R5 max at FF", v, 8'hFF);
    host_read(2, 11, v); chk("R5 min at 00", v, 8'h00);
    host_read(2, 1023, v); chk("R6 last pos min", v, 8'h80);

    // R6 other page still seeding
    send(1'b1, 3, 5, 8'h10);
    send(1'b1, 3, 5, 8'h20);
    idle(3);
    host_read(3, 10, v); chk("R6 page3 still seeds max", v, 8'h20);
    host_read(3, 11, v); chk("R6 page3 still seeds min", v, 8'h20);

    // R7 clear re-arms seeding of page 2
    do_clear(2);
    send(1'b1, 2, 5, 8'h60);
    idle(3);
    host_read(2, 10, v); chk("R7 reseed max", v, 8'h60);
    host_read(2, 11, v); chk("R7 reseed min", v, 8'h60);

    // R8 invalid pages
    send(1'b0, 6, 2, 8'hEE);
    @(negedge clk); chk("R8 err set", int'(err), 1);
    idle(1);
    send(1'b1, 7, 3, 8'hEE);
    @(negedge clk); chk("R8 no stall", int'(s_ready), 1);
    idle(3);
    @(negedge clk); chk("R8 err held", int'(err), 1);
    host_read(0, 2, v); chk("R8 page0 untouched", v, 2 * 17 + 1);
    host_read(0, 3, v); chk("R8 page0 untouched b", v, 3 * 17 + 1);
    do_clear(0);
    @(negedge clk); chk("R7 err cleared", int'(err), 0);

    // R9 read gating and invalid page read
    host_read(7, 4, v); chk("R9 bad page reads zero", v, 0);
    mode = 1'b1; page = 3'd4; s_pos = 9'd9; s_data = 8'h77; s_valid = 1'b1;
    @(negedge clk); chk("R9 refused while valid", int'(rd_ready), 0);
    @(posedge clk); #1; s_valid = 1'b0;
    @(negedge clk); chk("R9 refused while busy", int'(rd_ready), 0);
    idle(3);
    host_read(4, 19, v); chk("R9 read after merge", v, 8'h77);

    idle(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      failures++;
      $display("FAIL R3 watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule